// File: doc/BRIEF.md
# Clock Modulation Duty Controller

This block throttles a group of processor cores by gating each core's clock enable in a repeating pattern. A shared 16-slot frame counter runs continuously. In every frame, each core's enable is high for the first N slots and low for the rest. N is the duty chosen for that core, counted in sixteenths.

Three requesters can set N, and they win in a fixed order. The thermal-control request is highest. It carries a factory duty in sixteenths and applies to all cores. Next is the legacy I/O-style request, which has a 3-bit duty in eighths and also applies to all cores together. Lowest is the per-core control register. Its enable is at bit 4 and its duty code is at bits 3:1. When the fine-granularity input is high, bit 0 joins the code to make a 4-bit code in sixteenths.

The duty a core resolves to is latched only at a frame boundary, so a frame is never cut short. A duty code of zero from the winning source means full speed. When no source is active, every enable stays high.

Top module: `clkmod_duty_ctrl`

## Requirements
- R1: While `rst_n` is low, every bit of `core_clk_en` is 1. Asserting `rst_n` takes effect at once, without waiting for a clock edge.
- R2: When none of `tcc_req`, `io_req` or a core's register enable (bit 4 of its `core_ctrl` field) is active, that core's enable is 1 in all 16 slots of every frame.
- R3: When only its register enable is set, each core is gated by the duty in its own 5-bit field of `core_ctrl` (core i at bits 5i+4 down to 5i), independently of the other cores.
- R4: With `fine_mode` low, the register duty code is bits 3:1 of the field, the enable is high for 2×code slots per frame, and bit 0 has no effect.
- R5: With `fine_mode` high, the register duty code is bits 3:0 of the field, and the enable is high for code slots per frame.
- R6: A duty code of zero from the winning source gives an enable that is high in all 16 slots.
- R7: When `io_req` is high and `tcc_req` is low, every core is gated for 2×`io_duty` slots per frame, whatever the register fields hold and whatever `fine_mode` is.
- R8: When `tcc_req` is high, every core is gated for `tcc_duty` slots per frame (in sixteenths), overriding both other sources and ignoring `fine_mode`.
- R9: Within a 16-slot frame, the enabled slots are the first N slots, and the pattern repeats every 16 cycles.
- R10: A change in the requested duty takes effect only at the start of the next frame. The frame in progress completes with the old duty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of the frame counter and the duty registers |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fine_mode | input | 1 | 1: register duty in sixteenths (4-bit code); 0: in eighths (3-bit code) |
| core_ctrl | input | 20 | Per-core register fields, 5 bits each; bit 4 enable, bits 3:0 duty |
| io_req | input | 1 | Legacy all-core modulation request |
| io_duty | input | 3 | Duty of the legacy request, in eighths |
| tcc_req | input | 1 | Thermal-control modulation request (highest priority) |
| tcc_duty | input | 4 | Factory duty of the thermal request, in sixteenths |
| core_clk_en | output | 4 | Per-core clock enable, 1 = core clock runs in this cycle |

## Verification
The properties compare a duty latched at a frame boundary with the request inputs one cycle earlier. They therefore assume that all request and duty inputs are synchronous to `clk` and settle before each rising edge. They also assume that the frame holds at least as many slots as the fine duty code can express. The stimulus changes inputs only on the falling edge. Each setting is held for more than a full frame before any counting starts. The one exception is the mid-frame test for R10, which changes the register duty at a known slot.

// File: rtl/clkmod_pkg.sv
package clkmod_pkg;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_REG  = 2'd1,
    SRC_IO   = 2'd2,
    SRC_TCC  = 2'd3
  } src_e;

  // left shift that scales a code of code_bits to slots of a 2**frame_log2 frame
  function automatic int unsigned slot_shift(input int unsigned frame_log2,
                                             input int unsigned code_bits);
    return frame_log2 - code_bits;
  endfunction

endpackage

// File: rtl/clkmod_rst_sync.sv
module clkmod_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/clkmod_frame_ctr.sv
module clkmod_frame_ctr #(
  parameter int unsigned FRAME_LOG2 = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  output logic [FRAME_LOG2-1:0] slot,
  output logic                  frame_end
);

  logic [FRAME_LOG2-1:0] slot_q;
  logic [FRAME_LOG2-1:0] slot_d;
  logic                  cnt_en;

  assign cnt_en = 1'b1;

  always_comb begin
    slot_d = slot_q;
    if (cnt_en) begin
      slot_d = slot_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
    end else begin
      slot_q <= slot_d;
    end
  end

  assign slot      = slot_q;
  assign frame_end = (slot_q == {FRAME_LOG2{1'b1}});

  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (slot == '0)) else $error("frame did not wrap"); // R9

  AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> (slot == $past(slot) + 1'b1)) else $error("slot skipped"); // R9

endmodule

// File: rtl/clkmod_duty_arb.sv
module clkmod_duty_arb
  import clkmod_pkg::*;
#(
  parameter int unsigned COARSE_BITS = 3,
  parameter int unsigned FRAME_LOG2  = 4
) (
  input  logic                   fine_mode,
  input  logic [COARSE_BITS+1:0] reg_ctrl,
  input  logic                   io_req,
  input  logic [COARSE_BITS-1:0] io_duty,
  input  logic                   tcc_req,
  input  logic [FRAME_LOG2-1:0]  tcc_duty,
  output logic [FRAME_LOG2:0]    duty_slots
);

  localparam int unsigned FINE_BITS = COARSE_BITS + 1;
  localparam int unsigned EN_BIT    = FINE_BITS;
  localparam int unsigned CNT_W     = FRAME_LOG2 + 1;
  localparam int unsigned FRAME_LEN = 1 << FRAME_LOG2;
  localparam int unsigned SH_COARSE = slot_shift(FRAME_LOG2, COARSE_BITS);
  localparam int unsigned SH_FINE   = slot_shift(FRAME_LOG2, FINE_BITS);

  src_e             src;
  logic [CNT_W-1:0] reg_slots;
  logic [CNT_W-1:0] io_slots;
  logic [CNT_W-1:0] tcc_slots;
  logic [CNT_W-1:0] raw_slots;

  // fixed priority: thermal, then legacy I/O, then per-core register
  always_comb begin
    src = SRC_NONE;
    if (tcc_req) begin
      src = SRC_TCC;
    end else if (io_req) begin
      src = SRC_IO;
    end else if (reg_ctrl[EN_BIT]) begin
      src = SRC_REG;
    end
  end

  always_comb begin
    if (fine_mode) begin
      reg_slots = CNT_W'(reg_ctrl[FINE_BITS-1:0]) << SH_FINE;
    end else begin
      reg_slots = CNT_W'(reg_ctrl[FINE_BITS-1:1]) << SH_COARSE;
    end
    io_slots  = CNT_W'(io_duty) << SH_COARSE;
    tcc_slots = CNT_W'(tcc_duty);
  end

  always_comb begin
    unique case (src)
      SRC_TCC:  raw_slots = tcc_slots;
      SRC_IO:   raw_slots = io_slots;
      SRC_REG:  raw_slots = reg_slots;
      default:  raw_slots = '0;
    endcase
    // a zero code (or no source) means the clock is never gated
    if (raw_slots == '0) begin
      duty_slots = CNT_W'(FRAME_LEN);
    end else begin
      duty_slots = raw_slots;
    end
  end

endmodule

// File: rtl/clkmod_core_gate.sv
module clkmod_core_gate #(
  parameter int unsigned FRAME_LOG2 = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  frame_end,
  input  logic [FRAME_LOG2-1:0] slot,
  input  logic [FRAME_LOG2:0]   duty_next,
  output logic [FRAME_LOG2:0]   duty_cur,
  output logic                  clk_en
);

  localparam int unsigned CNT_W     = FRAME_LOG2 + 1;
  localparam int unsigned FRAME_LEN = 1 << FRAME_LOG2;

  logic [CNT_W-1:0] duty_q;
  logic [CNT_W-1:0] duty_d;

  always_comb begin
    duty_d = duty_q;
    if (frame_end) begin
      duty_d = duty_next;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_q <= CNT_W'(FRAME_LEN);
    end else begin
      duty_q <= duty_d;
    end
  end

  assign clk_en   = ({1'b0, slot} < duty_q);
  assign duty_cur = duty_q;

  AST_HOLD_MID_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(duty_q)) else $error("duty moved mid-frame"); // R10

  AST_SLOT0_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (slot == '0) |-> clk_en) else $error("first slot gated"); // R9

  AST_DUTY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_q != '0) && (duty_q <= CNT_W'(FRAME_LEN))) else $error("duty out of range"); // R6

endmodule

// File: rtl/clkmod_duty_ctrl.sv
module clkmod_duty_ctrl
  import clkmod_pkg::*;
#(
  parameter int unsigned CORES       = 4,
  parameter int unsigned COARSE_BITS = 3,
  parameter int unsigned FRAME_LOG2  = 4
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                fine_mode,
  input  logic [CORES*(COARSE_BITS+2)-1:0]    core_ctrl,
  input  logic                                io_req,
  input  logic [COARSE_BITS-1:0]              io_duty,
  input  logic                                tcc_req,
  input  logic [FRAME_LOG2-1:0]               tcc_duty,
  output logic [CORES-1:0]                    core_clk_en
);

  localparam int unsigned REG_W     = COARSE_BITS + 2;
  localparam int unsigned EN_BIT    = COARSE_BITS + 1;
  localparam int unsigned CNT_W     = FRAME_LOG2 + 1;
  localparam int unsigned FRAME_LEN = 1 << FRAME_LOG2;
  localparam int unsigned SH_COARSE = slot_shift(FRAME_LOG2, COARSE_BITS);

  logic                  rst_sync_n;
  logic [FRAME_LOG2-1:0] slot;
  logic                  frame_end;

  clkmod_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  clkmod_frame_ctr #(
    .FRAME_LOG2 (FRAME_LOG2)
  ) u_frame (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .slot      (slot),
    .frame_end (frame_end)
  );

  for (genvar gi = 0; gi < CORES; gi++) begin : g_core
    logic [REG_W-1:0] reg_field;
    logic [CNT_W-1:0] duty_next;
    logic [CNT_W-1:0] duty_cur;

    assign reg_field = core_ctrl[gi*REG_W +: REG_W];

    clkmod_duty_arb #(
      .COARSE_BITS (COARSE_BITS),
      .FRAME_LOG2  (FRAME_LOG2)
    ) u_arb (
      .fine_mode  (fine_mode),
      .reg_ctrl   (reg_field),
      .io_req     (io_req),
      .io_duty    (io_duty),
      .tcc_req    (tcc_req),
      .tcc_duty   (tcc_duty),
      .duty_slots (duty_next)
    );

    clkmod_core_gate #(
      .FRAME_LOG2 (FRAME_LOG2)
    ) u_gate (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .frame_end (frame_end),
      .slot      (slot),
      .duty_next (duty_next),
      .duty_cur  (duty_cur),
      .clk_en    (core_clk_en[gi])
    );

    AST_TCC_WINS: assert property (@(posedge clk) disable iff (!rst_sync_n)
      frame_end && tcc_req && (tcc_duty != '0)
      |=> (duty_cur == CNT_W'($past(tcc_duty)))) else $error("thermal duty lost"); // R8

    AST_IO_OVER_REG: assert property (@(posedge clk) disable iff (!rst_sync_n)
      frame_end && !tcc_req && io_req && (io_duty != '0)
      |=> (duty_cur == (CNT_W'($past(io_duty)) << SH_COARSE))) else $error("legacy duty lost"); // R7

    AST_IDLE_FULL: assert property (@(posedge clk) disable iff (!rst_sync_n)
      frame_end && !tcc_req && !io_req && !reg_field[EN_BIT]
      |=> (duty_cur == CNT_W'(FRAME_LEN))) else $error("idle core gated"); // R2
  end

endmodule

// File: tb/clkmod_duty_ctrl_test.sv
module clkmod_duty_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int NCORE      = 4;
  localparam int NVEC       = 10;

  logic        clk;
  logic        rst_n;
  logic        fine_mode;
  logic [19:0] core_ctrl;
  logic        io_req;
  logic [2:0]  io_duty;
  logic        tcc_req;
  logic [3:0]  tcc_duty;
  logic [3:0]  core_clk_en;

  int errs   = 0;
  int checks = 0;
  bit done   = 0;

  clkmod_duty_ctrl uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .fine_mode   (fine_mode),
    .core_ctrl   (core_ctrl),
    .io_req      (io_req),
    .io_duty     (io_duty),
    .tcc_req     (tcc_req),
    .tcc_duty    (tcc_duty),
    .core_clk_en (core_clk_en)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // vector: fine | core3..core0 fields | io_req io_duty | tcc_req tcc_duty | exp3..exp0 | req
  localparam logic [53:0] VECS [NVEC] = '{
    // R2: nothing requested
    {1'b0, 5'b00000,5'b00000,5'b00000,5'b00000, 1'b0,3'd0, 1'b0,4'd0, 5'd16,5'd16,5'd16,5'd16, 4'd2},
    // R3 R4: coarse, per-core duties, bit 0 ignored on core1
    {1'b0, 5'b10000,5'b01110,5'b10011,5'b10110, 1'b0,3'd0, 1'b0,4'd0, 5'd16,5'd16,5'd2,5'd6, 4'd4},
    // R5: fine codes
    {1'b1, 5'b10000,5'b11111,5'b10001,5'b10111, 1'b0,3'd0, 1'b0,4'd0, 5'd16,5'd15,5'd1,5'd7, 4'd5},
    // R7: legacy request overrides registers
    {1'b0, 5'b10000,5'b01110,5'b10011,5'b10110, 1'b1,3'd5, 1'b0,4'd0, 5'd10,5'd10,5'd10,5'd10, 4'd7},
    // R6: winning legacy code zero
    {1'b0, 5'b10000,5'b01110,5'b10011,5'b10110, 1'b1,3'd0, 1'b0,4'd0, 5'd16,5'd16,5'd16,5'd16, 4'd6},
    // R8: thermal overrides legacy
    {1'b0, 5'b10000,5'b01110,5'b10011,5'b10110, 1'b1,3'd5, 1'b1,4'd3, 5'd3,5'd3,5'd3,5'd3, 4'd8},
    // R8: thermal in sixteenths under fine mode
    {1'b1, 5'b10000,5'b11111,5'b10001,5'b10111, 1'b0,3'd0, 1'b1,4'd12, 5'd12,5'd12,5'd12,5'd12, 4'd8},
    // R7: legacy stays in eighths under fine mode
    {1'b1, 5'b10000,5'b11111,5'b10001,5'b10111, 1'b1,3'd1, 1'b0,4'd0, 5'd2,5'd2,5'd2,5'd2, 4'd7},
    // R4: coarse top code, others idle
    {1'b0, 5'b00000,5'b00000,5'b00000,5'b11111, 1'b0,3'd0, 1'b0,4'd0, 5'd16,5'd16,5'd16,5'd14, 4'd4},
    // R6: thermal code zero wins and leaves clocks running
    {1'b0, 5'b10000,5'b01110,5'b10011,5'b10110, 1'b1,3'd5, 1'b1,4'd0, 5'd16,5'd16,5'd16,5'd16, 4'd6}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic apply(input logic [53:0] v);
    fine_mode = v[53];
    core_ctrl = v[52:33];
    io_req    = v[32];
    io_duty   = v[31:29];
    tcc_req   = v[28];
    tcc_duty  = v[27:24];
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    rst_n     = 1'b0;
    fine_mode = 1'b0;
    core_ctrl = {4{5'b10010}};
    io_req    = 1'b0;
    io_duty   = 3'd0;
    tcc_req   = 1'b1;
    tcc_duty  = 4'd1;
    repeat (3) @(negedge clk);
    // R1: reset holds all enables open despite active requests
    check(core_clk_en == 4'hF, "R1 reset state", int'(core_clk_en), 15);
    rst_n = 1'b1;

    // table walk: count enabled slots over one full frame per core
    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk);
      apply(VECS[v]);
      repeat (20) @(negedge clk);
      begin
        int cnt [NCORE];
        for (int c = 0; c < NCORE; c++) cnt[c] = 0;
        for (int s = 0; s < 16; s++) begin
          for (int c = 0; c < NCORE; c++) cnt[c] += int'(core_clk_en[c]);
          @(negedge clk);
        end
        for (int c = 0; c < NCORE; c++) begin
          int exp_n;
          exp_n = int'(VECS[v][4+5*c +: 5]);
          checks++;
          if (cnt[c] != exp_n) begin
            errs++;
            $display("FAIL R%0d vector %0d core %0d: actual=%0d expected=%0d",
                     VECS[v][3:0], v, c, cnt[c], exp_n);
          end
        end
      end
    end

    // R9 R10: head-aligned pattern and change only at frame start
    apply({1'b0, 5'b00000,5'b00000,5'b00000,5'b10100, 1'b0,3'd0, 1'b0,4'd0, 20'd0, 4'd0});
    repeat (20) @(negedge clk);
    begin
      bit prev;
      bit found;
      prev  = core_clk_en[0];
      found = 1'b0;
      for (int t = 0; t < 40 && !found; t++) begin
        @(negedge clk);
        if (!prev && core_clk_en[0]) found = 1'b1;
        else prev = core_clk_en[0];
      end
      check(found, "R9 frame start seen", int'(found), 1);
      // now at slot 0 of a frame with duty 4
      check(core_clk_en[0] == 1'b1, "R9 slot 0", int'(core_clk_en[0]), 1);
      for (int k = 1; k < 4; k++) begin
        @(negedge clk);
        check(core_clk_en[0] == 1'b1, "R9 head slots", int'(core_clk_en[0]), 1);
      end
      // slot 3: request duty 12 in the middle of the frame
      core_ctrl[4:0] = 5'b11100;
      for (int k = 4; k < 16; k++) begin
        @(negedge clk);
        check(core_clk_en[0] == 1'b0, "R10 old duty kept mid-frame", int'(core_clk_en[0]), 0);
      end
      for (int k = 0; k < 16; k++) begin
        @(negedge clk);
        check(core_clk_en[0] == (k < 12), "R10 new duty next frame",
              int'(core_clk_en[0]), int'(k < 12));
      end
    end

    // R1: asynchronous reset during a gated slot
    apply({1'b1, 5'b00000,5'b00000,5'b00000,5'b10001, 1'b0,3'd0, 1'b0,4'd0, 20'd0, 4'd0});
    repeat (20) @(negedge clk);
    while (core_clk_en[0] == 1'b1) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(core_clk_en == 4'hF, "R1 async reset", int'(core_clk_en), 15);
    repeat (2) @(negedge clk);
    check(core_clk_en == 4'hF, "R1 reset held", int'(core_clk_en), 15);
    rst_n = 1'b1;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule